// File: doc/BRIEF.md
# Tone Transceiver Register Interface

This block is the register side of a tone-signalling transceiver. A small processor reaches it over a 4-bit data bus. The bus has an active-low chip select, separate active-low read and write strobes, and one register-select line. Through that bus the processor loads the code to transmit, picks up the most recent decoded receive code, programs two control registers that share one address, and polls a status register.

Decoded receive codes and tone-absence events come from a detector outside this block. The code arrives on a valid/code pair and the absence event on its own pulse. The block produces an interrupt, the code and enable for the tone generator, and the raw control settings.

In burst mode each transmit write starts a timed tone followed by a silent pause of equal length. The length is set in clock ticks by a parameter. When call-progress mode is selected the length doubles. The block signals that the transmit register is free again once the pause has ended.

Top module: `dtmf_regif`

## Requirements
- R1: After synchronous reset both control registers, the status register (all four bits), `dout`, `tone_en` and `irq` are zero.
- R2: With `rs` low, a write loads `din` into the transmit register (`tx_code`) and a read returns the last received code and clears the receive-ready flag (status bit 2). Read data appears on `dout` from the clock edge that samples the read strobe and is held afterwards.
- R3: With `rs` high, a write goes to control register A, with A bit 3 as the bank-select bit, unless A bit 3 is already set. In that case the write goes to control register B and A bit 3 clears, while the other A bits keep their values.
- R4: Outside burst mode (B bit 0 clear), `tone_en` equals A bit 0 and the transmit-free flag (status bit 1) stays zero.
- R5: In burst mode a transmit write accepted while the timer is idle holds `tone_en` high for exactly BURST_TICKS cycles, provided A bit 0 is set. A pause of BURST_TICKS cycles follows, and the transmit-free flag sets on the edge that ends the pause. While the timer is idle `tone_en` is low.
- R6: When A bit 1 (call-progress mode) is set in burst mode, the tone and the pause each last 2*BURST_TICKS cycles.
- R7: A transmit write during an active burst or pause is ignored: `tx_code` keeps its value and the running burst is not restarted.
- R8: A status read (`rs` high) returns {absent, rx-ready, tx-free, interrupt} as bits 3..0 and clears bits 0 and 1. The value returned is the one held before that read's edge.
- R9: A `rx_valid` pulse stores `rx_code`, sets the receive-ready flag and clears the tone-absent flag (bit 3). A `rx_absent` pulse sets the tone-absent flag.
- R10: While A bit 2 (interrupt enable) is set, a receive code, an absence event or a transmit-free event sets the interrupt flag (bit 0) on the same edge. `irq` follows that flag. While A bit 2 is clear these events leave `irq` low.
- R11: Each assertion of a strobe under chip select performs exactly one access, however many cycles the strobe is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rs | input | 1 | Register select: 0 data, 1 control/status |
| din | input | 4 | Write data bus |
| dout | output | 4 | Read data bus |
| rx_valid | input | 1 | One-cycle pulse: a decoded code is on rx_code |
| rx_code | input | 4 | Decoded receive code |
| rx_absent | input | 1 | One-cycle pulse: tone absence detected |
| irq | output | 1 | Interrupt request, active high |
| tone_en | output | 1 | Enable for the tone generator |
| tx_code | output | 4 | Code for the tone generator |
| cfg_a | output | 4 | Control register A contents |
| cfg_b | output | 4 | Control register B contents |

## Verification
The properties assume that every input is synchronous to `clk`. They assume `rd_n` and `wr_n` are never low together, and that a strobe is released for at least one clock edge between two accesses. `rx_valid` and `rx_absent` are taken as single-cycle pulses that never occur together. The stimulus changes inputs only on falling clock edges. Every bus task puts an idle edge before its strobe, and the receive pulses are driven one at a time for one cycle each, so the run stays inside these assumptions.

// File: rtl/dtmf_regif_pkg.sv
package dtmf_regif_pkg;

    localparam int unsigned DATA_W = 4;

    // status bits 3..0
    typedef struct packed {
        logic absent;
        logic rx_ready;
        logic tx_free;
        logic irq;
    } stat_t;

    // control register A bits 3..0
    typedef struct packed {
        logic sel_b;
        logic irq_en;
        logic cp_mode;
        logic tone_on;
    } cra_t;

    // control register B bits 3..0
    typedef struct packed {
        logic col_row;
        logic single;
        logic test;
        logic burst;
    } crb_t;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_TONE  = 2'd1,
        PH_PAUSE = 2'd2
    } phase_t;

    typedef struct packed {
        logic              wr_data;
        logic              rd_data;
        logic              wr_ctrl;
        logic              rd_stat;
        logic [DATA_W-1:0] val;
    } acc_t;

    function automatic acc_t decode_access(logic rd_new, logic wr_new,
                                           logic sel, logic [DATA_W-1:0] v);
        acc_t a;
        a.wr_data = wr_new & ~sel;
        a.rd_data = rd_new & ~sel;
        a.wr_ctrl = wr_new & sel;
        a.rd_stat = rd_new & sel;
        a.val     = v;
        return a;
    endfunction

endpackage

// File: rtl/dtmf_bus_if.sv
module dtmf_bus_if
    import dtmf_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    input  logic              rs,
    input  logic [DATA_W-1:0] din,
    output acc_t              acc
);
    logic rd_act, wr_act, rd_prev, wr_prev;

    assign rd_act = ~cs_n & ~rd_n;
    assign wr_act = ~cs_n & ~wr_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_prev <= 1'b0;
            wr_prev <= 1'b0;
        end else begin
            rd_prev <= rd_act;
            wr_prev <= wr_act;
        end
    end

    // one access per strobe assertion
    assign acc = decode_access(rd_act & ~rd_prev, wr_act & ~wr_prev, rs, din);
endmodule

// File: rtl/dtmf_burst_timer.sv
module dtmf_burst_timer
    import dtmf_regif_pkg::*;
#(
    parameter int unsigned TICKS = 25_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic burst_en,
    input  logic extended,
    input  logic start,
    output logic tone_phase,
    output logic idle,
    output logic done
);
    localparam int unsigned CW = $clog2(2 * TICKS + 1);
    localparam logic [CW-1:0] LEN_N = CW'(TICKS - 1);
    localparam logic [CW-1:0] LEN_X = CW'(2 * TICKS - 1);

    phase_t        ph;
    logic [CW-1:0] cnt;
    logic [CW-1:0] reload;

    assign reload     = extended ? LEN_X : LEN_N;
    assign tone_phase = (ph == PH_TONE);
    assign idle       = (ph == PH_IDLE);
    assign done       = (ph == PH_PAUSE) && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !burst_en) begin
            ph  <= PH_IDLE;
            cnt <= '0;
        end else begin
            unique case (ph)
                PH_IDLE: if (start) begin
                    ph  <= PH_TONE;
                    cnt <= reload;
                end
                PH_TONE: if (cnt == '0) begin
                    ph  <= PH_PAUSE;
                    cnt <= reload;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                PH_PAUSE: if (cnt == '0) begin
                    ph <= PH_IDLE;
                end else begin
                    cnt <= cnt - 1'b1;
                end
                default: ph <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/dtmf_status_regs.sv
module dtmf_status_regs
    import dtmf_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_valid,
    input  logic [DATA_W-1:0] rx_code,
    input  logic              rx_absent,
    input  logic              rd_data,
    input  logic              rd_stat,
    input  logic              tx_start,
    input  logic              burst_done,
    input  logic              burst_en,
    input  logic              irq_en,
    output stat_t             st,
    output logic [DATA_W-1:0] rx_reg
);
    logic free_evt, irq_evt;

    assign free_evt = burst_done & burst_en;
    assign irq_evt  = irq_en & (rx_valid | rx_absent | free_evt);

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            rx_reg <= '0;
        end else begin
            if (rx_valid) rx_reg <= rx_code;

            if (rx_valid)     st.rx_ready <= 1'b1;
            else if (rd_data) st.rx_ready <= 1'b0;

            if (rx_absent)     st.absent <= 1'b1;
            else if (rx_valid) st.absent <= 1'b0;

            if (!burst_en)                st.tx_free <= 1'b0;
            else if (free_evt)            st.tx_free <= 1'b1;
            else if (rd_stat || tx_start) st.tx_free <= 1'b0;

            if (irq_evt)      st.irq <= 1'b1;
            else if (rd_stat) st.irq <= 1'b0;
        end
    end
endmodule

// File: rtl/dtmf_regif.sv
module dtmf_regif
    import dtmf_regif_pkg::*;
#(
    parameter int unsigned BURST_TICKS = 25_000_000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cs_n,
    input  logic        rd_n,
    input  logic        wr_n,
    input  logic        rs,
    input  logic [3:0]  din,
    output logic [3:0]  dout,
    input  logic        rx_valid,
    input  logic [3:0]  rx_code,
    input  logic        rx_absent,
    output logic        irq,
    output logic        tone_en,
    output logic [3:0]  tx_code,
    output logic [3:0]  cfg_a,
    output logic [3:0]  cfg_b
);
    acc_t              acc;
    cra_t              cra;
    crb_t              crb;
    stat_t             st;
    logic [DATA_W-1:0] rx_reg;
    logic [DATA_W-1:0] dout_q;
    logic              tone_phase, t_idle, burst_done, tx_accept, tx_start;

    dtmf_bus_if u_bus (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .rs(rs), .din(din), .acc(acc)
    );

    assign tx_accept = acc.wr_data & (~crb.burst | t_idle);
    assign tx_start  = tx_accept & crb.burst;

    dtmf_burst_timer #(.TICKS(BURST_TICKS)) u_timer (
        .clk(clk), .rst(rst), .burst_en(crb.burst), .extended(cra.cp_mode),
        .start(tx_start), .tone_phase(tone_phase), .idle(t_idle),
        .done(burst_done)
    );

    dtmf_status_regs u_stat (
        .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_code(rx_code),
        .rx_absent(rx_absent), .rd_data(acc.rd_data), .rd_stat(acc.rd_stat),
        .tx_start(tx_start), .burst_done(burst_done), .burst_en(crb.burst),
        .irq_en(cra.irq_en), .st(st), .rx_reg(rx_reg)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cra     <= '0;
            crb     <= '0;
            tx_code <= '0;
            dout_q  <= '0;
        end else begin
            if (acc.wr_ctrl) begin
                if (cra.sel_b) begin
                    crb       <= crb_t'(acc.val);
                    cra.sel_b <= 1'b0;
                end else begin
                    cra <= cra_t'(acc.val);
                end
            end
            if (tx_accept)   tx_code <= acc.val;
            if (acc.rd_data) dout_q  <= rx_reg;
            if (acc.rd_stat) dout_q  <= st;
        end
    end

    assign dout    = dout_q;
    assign irq     = st.irq;
    assign tone_en = cra.tone_on & (crb.burst ? tone_phase : 1'b1);
    assign cfg_a   = cra;
    assign cfg_b   = crb;
endmodule

// File: rtl/dtmf_regif_chk.sv
module dtmf_regif_chk
    import dtmf_regif_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       irq,
    input logic       tone_en,
    input logic [3:0] cfg_a,
    input logic [3:0] cfg_b,
    input stat_t      st,
    input logic       wr_ctrl,
    input logic       rx_valid,
    input logic       rx_absent
);
    assert_tone_gate_R4: assert property (@(posedge clk) disable iff (rst)
        tone_en |-> cfg_a[0]);

    assert_nonburst_free_R4: assert property (@(posedge clk) disable iff (rst)
        !$past(cfg_b[0]) |-> !st.tx_free);

    assert_sel_clear_R3: assert property (@(posedge clk) disable iff (rst)
        $past(wr_ctrl && cfg_a[3]) |-> !cfg_a[3]);

    assert_rx_ready_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rx_valid) |-> st.rx_ready);

    assert_absent_set_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rx_absent) |-> st.absent);

    assert_irq_enable_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(cfg_a[2]));

    assert_free_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(st.tx_free) |-> !tone_en);
endmodule

bind dtmf_regif dtmf_regif_chk u_chk (
    .clk(clk), .rst(rst), .irq(irq), .tone_en(tone_en), .cfg_a(cfg_a),
    .cfg_b(cfg_b), .st(st), .wr_ctrl(acc.wr_ctrl), .rx_valid(rx_valid),
    .rx_absent(rx_absent)
);

// File: tb/sim_dtmf_regif.sv
module sim_dtmf_regif;
    localparam int unsigned TK = 12;

    logic clk = 1'b0, rst = 1'b1;
    logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, rs = 1'b0;
    logic [3:0] din = '0, rx_code = '0;
    logic rx_valid = 1'b0, rx_absent = 1'b0;
    logic [3:0] dout, tx_code, cfg_a, cfg_b;
    logic irq, tone_en;

    int nchk = 0, nfail = 0;
    bit done_flag = 0;

    typedef struct { logic [3:0] exp; string tag; } item_t;
    item_t sbq[$];
    event rd_ev;

    always #2 clk = ~clk;

    dtmf_regif #(.BURST_TICKS(TK)) u0 (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rs(rs),
        .din(din), .dout(dout), .rx_valid(rx_valid), .rx_code(rx_code),
        .rx_absent(rx_absent), .irq(irq), .tone_en(tone_en),
        .tx_code(tx_code), .cfg_a(cfg_a), .cfg_b(cfg_b)
    );

    task automatic chk(input int act, input int exp, input string tag);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done_flag) begin
            done_flag = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    // monitor side of the scoreboard
    initial forever begin
        @(rd_ev);
        while (sbq.size() > 0) begin
            item_t it;
            it = sbq.pop_front();
            chk(int'(dout), int'(it.exp), it.tag);
        end
    end

    task automatic bus_wr(input logic sel, input logic [3:0] v);
        @(negedge clk);
        rs = sel; din = v; cs_n = 0; wr_n = 0;
        @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic bus_wr_hold(input logic sel, input logic [3:0] v, input int n);
        @(negedge clk);
        rs = sel; din = v; cs_n = 0; wr_n = 0;
        repeat (n) @(negedge clk);
        cs_n = 1; wr_n = 1;
    endtask

    task automatic bus_rd(input logic sel, input logic [3:0] exp, input string tag);
        item_t it;
        @(negedge clk);
        rs = sel; cs_n = 0; rd_n = 0;
        @(negedge clk);
        cs_n = 1; rd_n = 1;
        it.exp = exp; it.tag = tag;
        sbq.push_back(it);
        ->rd_ev;
        #0;
    endtask

    task automatic rx_pulse(input logic [3:0] c);
        @(negedge clk);
        rx_valid = 1; rx_code = c;
        @(negedge clk);
        rx_valid = 0;
    endtask

    task automatic absent_pulse();
        @(negedge clk);
        rx_absent = 1;
        @(negedge clk);
        rx_absent = 0;
    endtask

    task automatic count_tone(output int n);
        n = 0;
        while (tone_en && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        chk(cfg_a, 0, "R1 cfg_a");
        chk(cfg_b, 0, "R1 cfg_b");
        chk(tone_en, 0, "R1 tone_en");
        chk(irq, 0, "R1 irq");
        chk(dout, 0, "R1 dout");
        bus_rd(1, 4'h0, "R1 status");

        // R2 data path
        bus_wr(0, 4'h5);
        chk(tx_code, 5, "R2 tx_code");
        rx_pulse(4'h9);
        bus_rd(1, 4'h4, "R9 rx_ready set");
        bus_rd(0, 4'h9, "R2 rx data");
        bus_rd(1, 4'h0, "R2 rx_ready cleared");

        // R9 absence flag
        absent_pulse();
        bus_rd(1, 4'h8, "R9 absent set");
        rx_pulse(4'h3);
        bus_rd(1, 4'h4, "R9 absent cleared by code");
        bus_rd(0, 4'h3, "R2 rx data second");

        // R3 shared control address
        bus_wr(1, 4'h8);
        chk(cfg_a, 8, "R3 bank select set");
        bus_wr(1, 4'h4);
        chk(cfg_b, 4, "R3 write reached B");
        chk(cfg_a, 0, "R3 bank select cleared");
        bus_wr(1, 4'h1);
        chk(cfg_a, 1, "R3 next write reaches A");
        chk(cfg_b, 4, "R3 B unchanged");

        // R4 non-burst
        chk(tone_en, 1, "R4 tone follows A0");
        bus_rd(1, 4'h0, "R4 tx_free stays clear");
        bus_wr(1, 4'h0);
        chk(tone_en, 0, "R4 tone off");

        // R11 held strobe performs one access
        bus_wr_hold(1, 4'h8, 4);
        chk(cfg_a, 8, "R11 held write to A");
        chk(cfg_b, 4, "R11 B untouched by held write");

        // enter burst mode
        bus_wr(1, 4'h1);
        chk(cfg_b, 1, "R3 burst bit in B");
        bus_wr(1, 4'h1);
        chk(tone_en, 0, "R5 idle timer tone low");

        // R5 burst timing
        bus_wr(0, 4'h7);
        chk(tx_code, 7, "R5 tx_code loaded");
        count_tone(n);
        chk(n, TK, "R5 tone length");
        bus_rd(1, 4'h0, "R5 tx_free clear during pause");
        repeat (8) @(negedge clk);
        bus_rd(1, 4'h0, "R5 tx_free clear on last pause edge");
        bus_rd(1, 4'h2, "R5 tx_free set after pause");
        bus_rd(1, 4'h0, "R8 status read clears tx_free");

        // R10 interrupt
        bus_wr(1, 4'h5);
        chk(irq, 0, "R10 irq idle");
        rx_pulse(4'hA);
        chk(irq, 1, "R10 irq on code");
        bus_rd(1, 4'h5, "R8 status with irq");
        chk(irq, 0, "R8 irq cleared by read");
        bus_rd(0, 4'hA, "R2 rx data third");
        bus_wr(1, 4'h1);
        absent_pulse();
        chk(irq, 0, "R10 no irq when disabled");
        bus_rd(1, 4'h8, "R10 status without irq");

        // R6 extended burst
        bus_wr(1, 4'h7);
        bus_wr(0, 4'h2);
        count_tone(n);
        chk(n, 2 * TK, "R6 extended tone length");
        n = 0;
        while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
        chk(n, 2 * TK, "R6 extended pause then R10 irq");
        bus_rd(1, 4'hB, "R10 irq from tx_free");

        // R7 write during burst ignored
        bus_wr(0, 4'h2);
        bus_wr(0, 4'h9);
        chk(tx_code, 2, "R7 tx_code kept");
        count_tone(n);
        chk(n, 2 * TK - 2, "R7 burst not restarted");
        n = 0;
        while (!irq && n < 1000) begin
            @(negedge clk);
            n++;
        end
        bus_rd(1, 4'hB, "R7 burst completes");

        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule